// File: doc/BRIEF.md
# Memory Ordering Issue Gate

The gate sits at the head of an in-order stream of memory operations and decides, cycle by cycle, whether the operation at the head may be passed to a memory system that can complete operations out of order. Each operation carries a kind, an ordering tag, an orderable flag, a cacheability flag and a small ID. Every issued operation occupies the window slot named by its ID until the memory system returns a visibility acknowledge for that ID. The memory system produces that acknowledge at the point the access class defines: the bus for uncacheable or write-coalescing accesses, a cache or store-buffer hit for cacheable loads, and entry into a snooped structure for cacheable stores.

Only orderable operations take part in ordering. An orderable operation is held back while any earlier orderable operation with acquire-like semantics (acquire or fence) is not yet visible. An orderable operation with release-like semantics (release or fence) is also held back while any earlier orderable operation at all is not yet visible. Because the gate only looks at the head of the stream, every slot in the window is older than the candidate. Operations whose kind and tag form an illegal pair are accepted and dropped, and they raise a one-cycle error pulse.

Each window slot is a two-state machine. In SLOT_IDLE the slot is free. The ALLOC transition takes it to SLOT_WAIT when an operation with that ID is issued. In SLOT_WAIT the slot is outstanding, and the SEEN transition returns it to SLOT_IDLE when the visibility acknowledge for that ID arrives. An acknowledge for a slot in SLOT_IDLE does nothing.

Top module: `mog_issue_gate`

## Requirements
- R1: After reset every slot is in SLOT_IDLE, `tag_err` is low, and with `issue_ready` high a legal head operation whose ID is free is issued in the same cycle (`issue_valid` and `in_ready` both high).
- R2: The kind is encoded 0 = load, 1 = store, 2 = atomic (compare-and-exchange or fetch-and-add), 3 = barrier. The tag is encoded 0 = unordered, 1 = acquire, 2 = release, 3 = fence. The legal pairs are load with unordered or acquire, store with unordered or release, atomic with acquire or release, and barrier with fence. An illegal head is never issued, `in_ready` is high for it, and `tag_err` is high for exactly the one cycle after it is accepted.
- R3: Operations that nothing holds back are issued back to back, one per cycle, combinationally in the cycle they are presented.
- R4: An orderable operation is not issued while any earlier orderable acquire or fence operation is awaiting its visibility acknowledge.
- R5: An orderable release or fence operation is not issued while any earlier orderable operation is awaiting its visibility acknowledge. A pending release does not hold back a later unordered operation.
- R6: A non-orderable operation (`in_ord` = 0) is issued regardless of pending operations, and once issued it holds back no later operation, whatever its tag.
- R7: `vis_valid` with `vis_id` frees that slot at the next clock edge. An acknowledge for a free slot has no effect.
- R8: An operation whose ID slot is still outstanding is stalled (`issue_valid` and `in_ready` low). When all 2^ID_W slots are outstanding, nothing is issued.
- R9: While `issue_ready` is low, a legal operation that is otherwise free to go shows `issue_valid` high but `in_ready` low, and no slot is allocated.
- R10: The issue port carries the head operation's ID, kind, tag, orderable flag and cacheability unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Head operation present |
| in_ready | output | 1 | Head operation consumed (issued or dropped) this cycle |
| in_kind | input | 2 | Operation kind |
| in_tag | input | 2 | Ordering tag |
| in_ord | input | 1 | Operation is orderable |
| in_cach | input | 1 | Operation targets cacheable memory |
| in_id | input | ID_W | Operation ID, which is also its window slot |
| issue_valid | output | 1 | Operation offered to the memory system |
| issue_ready | input | 1 | Memory system accepts the offered operation |
| issue_kind | output | 2 | Issued kind |
| issue_tag | output | 2 | Issued tag |
| issue_ord | output | 1 | Issued orderable flag |
| issue_cach | output | 1 | Issued cacheability |
| issue_id | output | ID_W | Issued ID |
| vis_valid | input | 1 | Visibility acknowledge present |
| vis_id | input | ID_W | ID that has become visible |
| tag_err | output | 1 | One-cycle pulse after an illegal pair is dropped |

## Verification
The bench builds the gate with the default ID_W of 3, which gives eight slots. That is small enough to fill the whole window with eight back-to-back issues and observe the full stall, and large enough to keep acquire, release, fence and non-orderable operations outstanding together in separate slots. With that setting a single vector table can walk every ID through both slot transitions. It also covers acknowledges that arrive in the same cycle a blocked operation is re-presented, and acknowledges sent to slots that are already free.

// File: rtl/mog_pkg.sv
`timescale 1ns/1ps
package mog_pkg;

    typedef enum logic [1:0] {
        K_LOAD    = 2'd0,
        K_STORE   = 2'd1,
        K_ATOMIC  = 2'd2,
        K_BARRIER = 2'd3
    } mog_kind_e;

    typedef enum logic [1:0] {
        T_UNORD = 2'd0,
        T_ACQ   = 2'd1,
        T_REL   = 2'd2,
        T_FENCE = 2'd3
    } mog_tag_e;

    typedef enum logic {
        SLOT_IDLE = 1'b0,
        SLOT_WAIT = 1'b1
    } slot_st_e;

    // Legal kind/tag pairings.
    function automatic logic mog_legal(input logic [1:0] k, input logic [1:0] t);
        logic ok;
        unique case (k)
            K_LOAD:    ok = (t == T_UNORD) || (t == T_ACQ);
            K_STORE:   ok = (t == T_UNORD) || (t == T_REL);
            K_ATOMIC:  ok = (t == T_ACQ)   || (t == T_REL);
            default:   ok = (t == T_FENCE);
        endcase
        return ok;
    endfunction

    // Holds back later orderable operations.
    function automatic logic mog_acq_like(input logic [1:0] t);
        return (t == T_ACQ) || (t == T_FENCE);
    endfunction

    // Waits for earlier orderable operations.
    function automatic logic mog_rel_like(input logic [1:0] t);
        return (t == T_REL) || (t == T_FENCE);
    endfunction

endpackage

// File: rtl/mog_slot.sv
`timescale 1ns/1ps
module mog_slot
    import mog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic alloc,
    input  logic alloc_ord,
    input  logic alloc_acq,
    input  logic seen,
    output logic busy,
    output logic hold_ord,
    output logic hold_acq
);

    slot_st_e state_q, state_d;
    logic     ord_q, acq_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_IDLE;
            ord_q   <= 1'b0;
            acq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (alloc) begin
                ord_q <= alloc_ord;
                acq_q <= alloc_acq;
            end
        end
    end

    // Transitions: ALLOC (idle->wait), SEEN (wait->idle)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_IDLE: if (alloc) state_d = SLOT_WAIT;
            SLOT_WAIT: if (seen)  state_d = SLOT_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy     = (state_q == SLOT_WAIT);
        hold_ord = busy && ord_q;
        hold_acq = busy && ord_q && acq_q;
    end

endmodule

// File: rtl/mog_gate.sv
`timescale 1ns/1ps
module mog_gate
    import mog_pkg::*;
#(
    parameter int ID_W  = 3,
    localparam int DEPTH = 1 << ID_W
) (
    input  logic [1:0]      kind,
    input  logic [1:0]      tag,
    input  logic            ord,
    input  logic [ID_W-1:0] id,
    input  logic [DEPTH-1:0] busy,
    input  logic [DEPTH-1:0] hold_ord,
    input  logic [DEPTH-1:0] hold_acq,
    output logic            legal,
    output logic            open
);

    logic any_acq, any_ord, id_taken;

    always_comb begin
        legal    = mog_legal(kind, tag);
        any_acq  = |hold_acq;
        any_ord  = |hold_ord;
        id_taken = busy[id];
        open     = !id_taken
                && !(ord && any_acq)
                && !(ord && mog_rel_like(tag) && any_ord);
    end

endmodule

// File: rtl/mog_issue_gate.sv
`timescale 1ns/1ps
module mog_issue_gate
    import mog_pkg::*;
#(
    parameter int ID_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [1:0]      in_kind,
    input  logic [1:0]      in_tag,
    input  logic            in_ord,
    input  logic            in_cach,
    input  logic [ID_W-1:0] in_id,
    output logic            issue_valid,
    input  logic            issue_ready,
    output logic [1:0]      issue_kind,
    output logic [1:0]      issue_tag,
    output logic            issue_ord,
    output logic            issue_cach,
    output logic [ID_W-1:0] issue_id,
    input  logic            vis_valid,
    input  logic [ID_W-1:0] vis_id,
    output logic            tag_err
);

    localparam int DEPTH = 1 << ID_W;

    logic [DEPTH-1:0] busy, hold_ord, hold_acq;
    logic             legal, open, fire, acq_in;

    mog_gate #(.ID_W(ID_W)) u_gate (
        .kind     (in_kind),
        .tag      (in_tag),
        .ord      (in_ord),
        .id       (in_id),
        .busy     (busy),
        .hold_ord (hold_ord),
        .hold_acq (hold_acq),
        .legal    (legal),
        .open     (open)
    );

    always_comb begin
        acq_in      = mog_acq_like(in_tag);
        issue_valid = in_valid && legal && open;
        in_ready    = !legal || (open && issue_ready);
        fire        = issue_valid && issue_ready;
        issue_kind  = in_kind;
        issue_tag   = in_tag;
        issue_ord   = in_ord;
        issue_cach  = in_cach;
        issue_id    = in_id;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        mog_slot u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .alloc     (fire && (in_id == ID_W'(i))),
            .alloc_ord (in_ord),
            .alloc_acq (acq_in),
            .seen      (vis_valid && (vis_id == ID_W'(i))),
            .busy      (busy[i]),
            .hold_ord  (hold_ord[i]),
            .hold_acq  (hold_acq[i])
        );
    end

    // One-cycle pulse for a dropped illegal pairing
    always_ff @(posedge clk) begin
        if (!rst_n) tag_err <= 1'b0;
        else        tag_err <= in_valid && !legal;
    end

endmodule

// File: rtl/mog_issue_gate_chk.sv
`timescale 1ns/1ps
module mog_issue_gate_chk
    import mog_pkg::*;
#(
    parameter int ID_W = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            in_ready,
    input logic            issue_valid,
    input logic            issue_ready,
    input logic [1:0]      issue_kind,
    input logic [1:0]      issue_tag,
    input logic            issue_ord,
    input logic [ID_W-1:0] issue_id,
    input logic            vis_valid,
    input logic [ID_W-1:0] vis_id,
    input logic            tag_err
);

    localparam int DEPTH = 1 << ID_W;

    logic [DEPTH-1:0] sh_busy, sh_ord, sh_acq;

    // Shadow of outstanding operations rebuilt from port traffic
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_busy <= '0;
            sh_ord  <= '0;
            sh_acq  <= '0;
        end else begin
            if (vis_valid) sh_busy[vis_id] <= 1'b0;
            if (issue_valid && issue_ready) begin
                sh_busy[issue_id] <= 1'b1;
                sh_ord[issue_id]  <= issue_ord;
                sh_acq[issue_id]  <= mog_acq_like(issue_tag);
            end
        end
    end

    // R2
    legal_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> mog_legal(issue_kind, issue_tag));

    // R2
    err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tag_err |-> $past(in_valid && in_ready && !issue_valid));

    // R4
    acq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_ord) |-> !(|(sh_busy & sh_ord & sh_acq)));

    // R5
    rel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_ord && mog_rel_like(issue_tag)) |-> !(|(sh_busy & sh_ord)));

    // R8
    id_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> !sh_busy[issue_id]);

    // R9
    backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !issue_ready) |-> !in_ready);

endmodule

bind mog_issue_gate mog_issue_gate_chk #(.ID_W(ID_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .issue_valid (issue_valid),
    .issue_ready (issue_ready),
    .issue_kind  (issue_kind),
    .issue_tag   (issue_tag),
    .issue_ord   (issue_ord),
    .issue_id    (issue_id),
    .vis_valid   (vis_valid),
    .vis_id      (vis_id),
    .tag_err     (tag_err)
);

// File: tb/mog_issue_gate_tb.sv
`timescale 1ns/1ps
module mog_issue_gate_tb;

    localparam int ID_W = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0, in_ord = 1'b0, in_cach = 1'b0;
    logic [1:0]      in_kind = '0, in_tag = '0;
    logic [ID_W-1:0] in_id = '0, vis_id = '0;
    logic            issue_ready = 1'b1, vis_valid = 1'b0;
    logic            in_ready, issue_valid, issue_ord, issue_cach, tag_err;
    logic [1:0]      issue_kind, issue_tag;
    logic [ID_W-1:0] issue_id;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    mog_issue_gate #(.ID_W(ID_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_kind(in_kind), .in_tag(in_tag), .in_ord(in_ord),
        .in_cach(in_cach), .in_id(in_id),
        .issue_valid(issue_valid), .issue_ready(issue_ready),
        .issue_kind(issue_kind), .issue_tag(issue_tag),
        .issue_ord(issue_ord), .issue_cach(issue_cach), .issue_id(issue_id),
        .vis_valid(vis_valid), .vis_id(vis_id), .tag_err(tag_err)
    );

    typedef struct packed {
        logic       v;
        logic [1:0] k;
        logic [1:0] t;
        logic       o;
        logic       c;
        logic [2:0] id;
        logic       av;
        logic [2:0] aid;
        logic       ir;
        logic       ei;
        logic       er;
    } vec_t;

    // kind: 0 load 1 store 2 atomic 3 barrier; tag: 0 unord 1 acq 2 rel 3 fence
    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        '{1'b1,2'd0,2'd0,1'b1,1'b1,3'd0,1'b0,3'd0,1'b1,1'b1,1'b1}, // R3 load id0
        '{1'b1,2'd1,2'd0,1'b1,1'b1,3'd1,1'b0,3'd0,1'b1,1'b1,1'b1}, // R3 store id1
        '{1'b1,2'd0,2'd1,1'b1,1'b1,3'd2,1'b0,3'd0,1'b1,1'b1,1'b1}, // R4 acquire id2
        '{1'b1,2'd0,2'd0,1'b1,1'b1,3'd3,1'b0,3'd0,1'b1,1'b0,1'b0}, // R4 held by acq
        '{1'b1,2'd0,2'd0,1'b0,1'b1,3'd3,1'b0,3'd0,1'b1,1'b1,1'b1}, // R6 non-orderable
        '{1'b1,2'd1,2'd2,1'b1,1'b1,3'd4,1'b1,3'd2,1'b1,1'b0,1'b0}, // R5 release held
        '{1'b1,2'd1,2'd2,1'b1,1'b1,3'd4,1'b1,3'd0,1'b1,1'b0,1'b0}, // R5 still held
        '{1'b1,2'd1,2'd2,1'b1,1'b1,3'd4,1'b1,3'd1,1'b1,1'b0,1'b0}, // R5 still held
        '{1'b1,2'd1,2'd2,1'b1,1'b1,3'd4,1'b0,3'd0,1'b1,1'b1,1'b1}, // R5 release goes
        '{1'b1,2'd0,2'd0,1'b1,1'b1,3'd5,1'b0,3'd0,1'b1,1'b1,1'b1}, // R5 later unord passes
        '{1'b1,2'd0,2'd0,1'b1,1'b1,3'd3,1'b0,3'd0,1'b1,1'b0,1'b0}, // R8 id busy
        '{1'b1,2'd0,2'd0,1'b1,1'b1,3'd3,1'b1,3'd3,1'b1,1'b0,1'b0}, // R7 ack, takes effect next
        '{1'b1,2'd0,2'd0,1'b1,1'b1,3'd3,1'b0,3'd0,1'b0,1'b1,1'b0}, // R9 backpressure
        '{1'b1,2'd0,2'd0,1'b1,1'b1,3'd3,1'b0,3'd0,1'b1,1'b1,1'b1}, // R7 freed id3 reused
        '{1'b0,2'd0,2'd0,1'b0,1'b0,3'd0,1'b1,3'd4,1'b1,1'b0,1'b1}, // idle head
        '{1'b1,2'd3,2'd3,1'b1,1'b0,3'd6,1'b1,3'd3,1'b1,1'b0,1'b0}, // R5 fence held
        '{1'b1,2'd3,2'd3,1'b1,1'b0,3'd6,1'b1,3'd5,1'b1,1'b0,1'b0}, // R5 fence held
        '{1'b1,2'd3,2'd3,1'b1,1'b0,3'd6,1'b0,3'd0,1'b1,1'b1,1'b1}, // R5 fence goes
        '{1'b1,2'd2,2'd2,1'b1,1'b1,3'd7,1'b1,3'd6,1'b1,1'b0,1'b0}, // R4 fence holds atomic
        '{1'b1,2'd2,2'd2,1'b1,1'b1,3'd7,1'b0,3'd0,1'b1,1'b1,1'b1}, // R4 atomic goes
        '{1'b1,2'd1,2'd3,1'b1,1'b1,3'd0,1'b1,3'd7,1'b1,1'b0,1'b1}  // R2 store+fence illegal
    };

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [1:0] k, input logic [1:0] t,
                         input logic o, input logic c, input logic [2:0] id,
                         input logic av, input logic [2:0] aid, input logic ir);
        in_valid = v; in_kind = k; in_tag = t; in_ord = o; in_cach = c; in_id = id;
        vis_valid = av; vis_id = aid; issue_ready = ir;
        #1;
    endtask

    task automatic nxt();
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        drive(1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 3'd0, 1'b0, 3'd0, 1'b1);
        chk({7'd0, tag_err}, 8'd0, "R1 tag_err after reset");
        chk({7'd0, issue_valid}, 8'd0, "R1 no issue while idle");
        chk({7'd0, in_ready}, 8'd1, "R1 ready after reset");
        nxt();

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].v, VEC[i].k, VEC[i].t, VEC[i].o, VEC[i].c, VEC[i].id,
                  VEC[i].av, VEC[i].aid, VEC[i].ir);
            chk({7'd0, issue_valid}, {7'd0, VEC[i].ei}, $sformatf("vec %0d issue_valid", i));
            chk({7'd0, in_ready}, {7'd0, VEC[i].er}, $sformatf("vec %0d in_ready", i));
            nxt();
        end

        // R2: pulse for the dropped store+fence lasts exactly one cycle
        drive(1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 3'd0, 1'b0, 3'd0, 1'b1);
        chk({7'd0, tag_err}, 8'd1, "R2 error pulse");
        nxt();
        drive(1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 3'd0, 1'b0, 3'd0, 1'b1);
        chk({7'd0, tag_err}, 8'd0, "R2 pulse ends");
        nxt();

        // R2: load+release and barrier+unordered are illegal; atomic+acquire is legal
        drive(1'b1, 2'd0, 2'd2, 1'b1, 1'b1, 3'd2, 1'b0, 3'd0, 1'b1);
        chk({7'd0, issue_valid}, 8'd0, "R2 load+release not issued");
        chk({7'd0, in_ready}, 8'd1, "R2 load+release dropped");
        nxt();
        drive(1'b1, 2'd3, 2'd0, 1'b1, 1'b1, 3'd2, 1'b0, 3'd0, 1'b1);
        chk({7'd0, tag_err}, 8'd1, "R2 pulse for load+release");
        chk({7'd0, issue_valid}, 8'd0, "R2 barrier+unordered not issued");
        nxt();

        // R6 / R10: non-orderable atomic acquire, fields pass through
        drive(1'b1, 2'd2, 2'd1, 1'b0, 1'b0, 3'd5, 1'b0, 3'd0, 1'b1);
        chk({7'd0, issue_valid}, 8'd1, "R6 non-orderable acquire issued");
        chk({3'd0, issue_ord, issue_cach, issue_id}, {3'd0, 1'b0, 1'b0, 3'd5}, "R10 id/ord/cach");
        chk({4'd0, issue_kind, issue_tag}, {4'd0, 2'd2, 2'd1}, "R10 kind/tag");
        nxt();
        drive(1'b1, 2'd0, 2'd0, 1'b1, 1'b1, 3'd1, 1'b0, 3'd0, 1'b1);
        chk({7'd0, issue_valid}, 8'd1, "R6 later orderable not held");
        nxt();

        // R7: spurious ack to free id2 leaves busy id1 outstanding
        drive(1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 3'd0, 1'b1, 3'd2, 1'b1);
        nxt();
        drive(1'b1, 2'd0, 2'd0, 1'b0, 1'b1, 3'd1, 1'b1, 3'd1, 1'b1);
        chk({7'd0, in_ready}, 8'd0, "R7 id1 still busy after stray ack");
        nxt();
        drive(1'b1, 2'd0, 2'd0, 1'b0, 1'b1, 3'd1, 1'b1, 3'd5, 1'b1);
        chk({7'd0, issue_valid}, 8'd1, "R7 id1 freed by its ack");
        nxt();
        drive(1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 3'd0, 1'b1, 3'd1, 1'b1);
        nxt();

        // R8: fill all eight slots, then the window stalls
        for (int i = 0; i < 8; i++) begin
            drive(1'b1, 2'd0, 2'd0, 1'b0, 1'b1, 3'(i), 1'b0, 3'd0, 1'b1);
            chk({7'd0, issue_valid}, 8'd1, $sformatf("R8 fill id %0d", i));
            nxt();
        end
        for (int i = 0; i < 8; i++) begin
            drive(1'b1, 2'd0, 2'd0, 1'b0, 1'b1, 3'(i), 1'b0, 3'd0, 1'b1);
            chk({6'd0, issue_valid, in_ready}, 8'd0, $sformatf("R8 full stall id %0d", i));
            nxt();
        end
        drive(1'b1, 2'd0, 2'd0, 1'b0, 1'b1, 3'd4, 1'b1, 3'd4, 1'b1);
        chk({7'd0, issue_valid}, 8'd0, "R8 stall in ack cycle");
        nxt();
        drive(1'b1, 2'd0, 2'd0, 1'b0, 1'b1, 3'd4, 1'b0, 3'd0, 1'b1);
        chk({7'd0, issue_valid}, 8'd1, "R8 slot reused after ack");
        nxt();

        // R1: reset empties the window
        rst_n = 1'b0;
        nxt(); nxt();
        rst_n = 1'b1;
        drive(1'b1, 2'd0, 2'd0, 1'b1, 1'b1, 3'd4, 1'b0, 3'd0, 1'b1);
        chk({6'd0, issue_valid, in_ready}, 8'd3, "R1 window empty after reset");
        nxt();

        done = 1'b1;
        summary();
    end

endmodule